// File: doc/BRIEF.md
# Carrier Keying Data Modulator

The block keys a serial data bit onto carrier square waves. Two programmable dividers derive a fast "mark" carrier and a slow "space" carrier from the system clock. On every clock the mixer picks the mark carrier when the data bit is 1. When the data bit is 0 it picks a space source, and the keying mode sets that source: a constant low, the slow carrier, or the inverted mark carrier. This gives on-off, frequency-shift or phase-shift keying from one AND-OR path.

An optional output inversion follows the mixer. The result is registered once. The mode and data inputs are not aligned to carrier edges, so a change in either one can cut a carrier cycle short at the output. Framing of the data stream and any line driver sit outside the block.

Top module: `carrier_keyer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `keyed_out` is 0 after that edge and both carriers and their counters restart from low and zero.
- R2: The mark carrier starts low after reset and inverts every `mark_div`+1 clocks, giving a 50 % duty square wave.
- R3: The space carrier starts low after reset and inverts every `space_div`+1 clocks.
- R4: When `data_bit` is 1, the output equals the mark carrier in every mode.
- R5: With `key_mode` = 2'b00 (on-off) and `data_bit` 0, the output is constant low.
- R6: With `key_mode` = 2'b01 (frequency shift) and `data_bit` 0, the output equals the space carrier.
- R7: With `key_mode` = 2'b10 (phase shift) and `data_bit` 0, the output equals the inverse of the mark carrier.
- R8: `key_mode` = 2'b11 is reserved and behaves as on-off keying.
- R9: When `invert_out` is 1, the output is the inverse of the value that R4 to R8 give. This does not apply during reset.
- R10: `keyed_out` shows the mixed value of the inputs and carriers from the previous clock, one cycle of latency. A change of `data_bit` or `key_mode` takes effect at the next edge, whatever the carrier phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_bit | input | 1 | Serial data to key |
| key_mode | input | 2 | 00 on-off, 01 frequency shift, 10 phase shift, 11 reserved (on-off) |
| invert_out | input | 1 | Inverts the keyed output |
| mark_div | input | DIV_W | Mark carrier half-period minus one, in clocks |
| space_div | input | DIV_W | Space carrier half-period minus one, in clocks |
| keyed_out | output | 1 | Registered modulated output |

## Verification
The hardest case to reach is a change of data or mode in the middle of a carrier half-period, where the output must cut the carrier short. The carriers cannot be seen at the ports. The stimulus therefore makes the bench rebuild the carrier phase from the divider settings it applied at reset. It then changes `data_bit` and `key_mode` on every clock for a stretch, so that every switch lands at a different carrier phase. Setting a divider to zero gives a carrier that inverts every clock, which exercises the fastest phase relation.

// File: rtl/km_pkg.sv
// Package: shared mode encoding for the carrier keyer.
// Assumes a two-bit mode field; the fourth code is reserved.
package km_pkg;
    typedef enum logic [1:0] {
        KEY_ONOFF = 2'b00,
        KEY_FREQ  = 2'b01,
        KEY_PHASE = 2'b10,
        KEY_RSVD  = 2'b11
    } key_mode_e;

    localparam int unsigned NUM_CARRIERS = 2;
    localparam int unsigned CAR_MARK     = 0;
    localparam int unsigned CAR_SPACE    = 1;
endpackage

// File: rtl/km_div.sv
// Carrier divider: square wave that inverts every half+1 clocks.
// Assumes half is held steady between resets; a smaller value written
// while running is caught by the >= compare and does not wrap the counter.
module km_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half,
    output logic             wave
);
    logic [DIV_W-1:0] cnt_q;

    // Count clocks in the current half-period and invert at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wave  <= 1'b0;
        end else if (cnt_q >= half) begin
            cnt_q <= '0;
            wave  <= ~wave;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/km_mix.sv
// Mixer: out = (data & mark) | (~data & space_src), space_src picked by mode,
// then optional inversion and one output register.
// Assumes no alignment of data or mode to carrier edges.
module km_mix
    import km_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_bit,
    input  logic [1:0] key_mode,
    input  logic       invert_out,
    input  logic       mark_car,
    input  logic       space_car,
    output logic       keyed_out
);
    logic space_src;
    logic mixed;

    // Select what drives the space (data 0) term.
    always_comb begin
        unique case (key_mode_e'(key_mode))
            KEY_FREQ:  space_src = space_car;
            KEY_PHASE: space_src = ~mark_car;
            default:   space_src = 1'b0;
        endcase
    end

    // AND-OR mixing path followed by the polarity stage.
    always_comb begin
        mixed = (data_bit & mark_car) | (~data_bit & space_src);
        mixed = mixed ^ invert_out;
    end

    // Register the keyed result.
    always_ff @(posedge clk) begin
        if (!rst_n) keyed_out <= 1'b0;
        else        keyed_out <= mixed;
    end
endmodule

// File: rtl/carrier_keyer.sv
// Top: two carrier dividers feeding one keying mixer.
// Assumes the divider settings are static while keying.
module carrier_keyer
    import km_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_bit,
    input  logic [1:0]       key_mode,
    input  logic             invert_out,
    input  logic [DIV_W-1:0] mark_div,
    input  logic [DIV_W-1:0] space_div,
    output logic             keyed_out
);
    logic [DIV_W-1:0]        half_set [NUM_CARRIERS];
    logic [NUM_CARRIERS-1:0] car;
    logic                    mark_car;
    logic                    space_car;

    // Route the divider settings to their carrier slots.
    always_comb begin
        half_set[CAR_MARK]  = mark_div;
        half_set[CAR_SPACE] = space_div;
    end

    for (genvar g = 0; g < NUM_CARRIERS; g++) begin : g_car
        km_div #(.DIV_W(DIV_W)) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .half (half_set[g]),
            .wave (car[g])
        );
    end

    assign mark_car  = car[CAR_MARK];
    assign space_car = car[CAR_SPACE];

    km_mix u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_bit  (data_bit),
        .key_mode  (key_mode),
        .invert_out(invert_out),
        .mark_car  (mark_car),
        .space_car (space_car),
        .keyed_out (keyed_out)
    );
endmodule

// File: rtl/km_check.sv
// Checker: relates the registered output to the carriers and inputs of the
// previous clock. Attached to every carrier_keyer by the bind below.
module km_check (
    input logic       clk,
    input logic       rst_n,
    input logic       data_bit,
    input logic [1:0] key_mode,
    input logic       invert_out,
    input logic       mark_car,
    input logic       space_car,
    input logic       keyed_out
);
    // R4 / R9: a data 1 passes the mark carrier
    a_r4_mark_passes: assert property (@(posedge clk) disable iff (!rst_n)
        data_bit |=> keyed_out == ($past(mark_car) ^ $past(invert_out)));

    // R5 / R8: on-off and reserved modes give a quiet space
    a_r5_onoff_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_bit && (key_mode[1] == key_mode[0])) |=> keyed_out == $past(invert_out));

    // R6: frequency shift passes the slow carrier on a space
    a_r6_freq_space: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_bit && key_mode == 2'b01) |=> keyed_out == ($past(space_car) ^ $past(invert_out)));

    // R7: phase shift passes the inverted mark carrier on a space
    a_r7_phase_space: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_bit && key_mode == 2'b10) |=> keyed_out == (~$past(mark_car) ^ $past(invert_out)));

    // R1: reset drives the output low
    a_r1_reset_low: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> !keyed_out);
endmodule

bind carrier_keyer km_check u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_bit  (data_bit),
    .key_mode  (key_mode),
    .invert_out(invert_out),
    .mark_car  (mark_car),
    .space_car (space_car),
    .keyed_out (keyed_out)
);

// File: tb/sim_carrier_keyer.sv
module sim_carrier_keyer;
    localparam int DIV_W = 8;

    typedef struct {
        logic  val;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             data_bit = 1'b0;
    logic [1:0]       key_mode = 2'b00;
    logic             invert_out = 1'b0;
    logic [DIV_W-1:0] mark_div = 8'd2;
    logic [DIV_W-1:0] space_div = 8'd6;
    logic             keyed_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit fast_phase = 1'b0;
    exp_t exp_q[$];

    // reference carrier state, built from R2/R3
    int  m_cnt = 0, s_cnt = 0;
    bit  m_car = 0, s_car = 0;

    carrier_keyer #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .data_bit(data_bit), .key_mode(key_mode),
        .invert_out(invert_out), .mark_div(mark_div), .space_div(space_div),
        .keyed_out(keyed_out)
    );

    always #4 clk = ~clk;  // 125 MHz

    // Model: compute what the output will be after this edge, then advance carriers.
    always @(posedge clk) begin
        exp_t e;
        bit   sp;
        if (!rst_n) begin
            m_cnt = 0; s_cnt = 0; m_car = 0; s_car = 0;
        end else begin
            case (key_mode)
                2'b01:   sp = s_car;
                2'b10:   sp = ~m_car;
                default: sp = 1'b0;
            endcase
            e.val = (data_bit ? m_car : sp) ^ invert_out;
            if (data_bit)              e.tag = "R2 R4";
            else if (key_mode == 2'b00) e.tag = "R5";
            else if (key_mode == 2'b01) e.tag = "R3 R6";
            else if (key_mode == 2'b10) e.tag = "R7";
            else                       e.tag = "R8";
            if (invert_out) e.tag = {e.tag, " R9"};
            if (fast_phase) e.tag = {e.tag, " R10"};
            exp_q.push_back(e);
            if (m_cnt >= int'(mark_div))  begin m_cnt = 0; m_car = ~m_car; end else m_cnt++;
            if (s_cnt >= int'(space_div)) begin s_cnt = 0; s_car = ~s_car; end else s_cnt++;
        end
    end

    // Monitor: one expected item per edge, compared mid-cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (keyed_out !== e.val) begin
                n_fail++;
                $display("FAIL %s: keyed_out=%0b expected=%0b", e.tag, keyed_out, e.val);
            end
        end
    end

    task automatic drive(input bit d, input logic [1:0] m, input int cycles);
        @(negedge clk);
        data_bit = d;
        key_mode = m;
        repeat (cycles - 1) @(negedge clk);
    endtask

    task automatic do_reset(input logic [DIV_W-1:0] md, input logic [DIV_W-1:0] sd);
        @(negedge clk);
        rst_n = 1'b0;
        mark_div = md;
        space_div = sd;
        repeat (3) @(negedge clk);
        // R1: output low while held in reset
        n_checks++;
        if (keyed_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: keyed_out=%0b expected=0", keyed_out);
        end
        rst_n = 1'b1;
    endtask

    task automatic sweep();
        for (int m = 0; m < 4; m++) begin
            drive(1'b1, 2'(m), 17);
            drive(1'b0, 2'(m), 23);
        end
        // R10: switch data and mode every clock at shifting carrier phase
        fast_phase = 1'b1;
        for (int i = 0; i < 60; i++)
            drive(1'((i * 7 + i / 3) % 2), 2'((i * 5 + 1) % 4), 1);
        fast_phase = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset(8'd2, 8'd6);
        sweep();
        invert_out = 1'b1;  // R9
        sweep();
        invert_out = 1'b0;
        do_reset(8'd0, 8'd3);   // fastest mark carrier
        sweep();
        invert_out = 1'b1;
        do_reset(8'd4, 8'd0);   // space faster than mark
        sweep();
        invert_out = 1'b0;
        do_reset(8'd1, 8'd9);
        sweep();
        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule